// File: doc/BRIEF.md
# Sub-GHz Radio Control Port (SPI Command Slave)

This block is the host-facing control port of a sub-GHz radio. A host talks to it over a four-wire serial link in clock mode 0, most significant bit first. Each transaction runs while the active-low select is held low. The first byte from the host is a command. While that byte shifts in, the block shifts out a status byte built from two radio-side flags. The bytes that follow either update storage or read it back.

The storage is four byte arrays. The first holds ten configuration bytes. The others are a 32-byte outgoing payload, a 4-byte outgoing destination address and a 32-byte incoming payload. The radio side fills the incoming payload through a simple write port. All four arrays are visible on output buses.

The serial pins are brought into a fast system clock through synchronizers. Edges are detected there, so the serial clock must be well below a quarter of the system clock rate. For a configuration command, the low nibble of the command byte gives the start register. For a channel command, the low nibble carries channel and band fields.

Top module: `spi_radio_ctl_port`

## Requirements
- R1: Serial transfer uses clock mode 0, most significant bit first. MOSI is sampled on rising SCK. MISO changes after falling SCK. Bytes are counted from the start of each select-low window.
- R2: During the first byte, MISO carries a status byte captured when select falls. Bit 7 is `addr_match` and bit 5 is `data_ready`. All other bits are 0.
- R3: A command whose upper nibble is 0x0 writes configuration registers. The first data byte goes to the register named by the command's low nibble, and each further byte goes to the next register up.
- R4: A command whose upper nibble is 0x1 reads configuration registers. The first data byte position returns the register named by the low nibble, and each further position returns the next register up.
- R5: Configuration addresses run from 0 to 9. With a start address of 10 to 15 the whole command is ignored: no write happens and reads return 0x00. Bytes that would land above address 9 are dropped on write and return 0x00 on read.
- R6: Command 0x20 writes the outgoing payload from index 0 upward. Command 0x21 returns it from index 0 upward.
- R7: Command 0x22 writes the 4-byte destination address from index 0 upward. Command 0x23 returns it from index 0 upward.
- R8: Command 0x24 returns the incoming payload from index 0 upward. That buffer is written only through `rx_wr_en`, `rx_wr_idx` and `rx_wr_data`.
- R9: A command with upper nibble 0x8 sets the channel. Its bits 3:0 replace bits 3:0 of configuration register 1. Bits 3:2 are the PA level, bit 1 is the band select and bit 0 is channel bit 8, while bits 7:4 of register 1 are kept. The next data byte goes to register 0 as channel bits 7:0, and any later bytes are ignored.
- R10: A write past the end of a buffer is ignored. A read past the end returns 0x00. This also applies to an incoming-payload write with an index of 32 or more.
- R11: Raising select ends the transaction at once. A partly shifted byte has no effect, and the next transaction starts again with a command byte.
- R12: An unrecognised command changes no storage. After its status byte, MISO returns 0x00, as it also does during the data bytes of any write command.
- R13: After reset, all storage and all output buses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low transaction select |
| mosi | input | 1 | Serial data from the host |
| addr_match | input | 1 | Radio flag reported in status bit 7 |
| data_ready | input | 1 | Radio flag reported in status bit 5 |
| rx_wr_en | input | 1 | Incoming-payload write strobe |
| rx_wr_idx | input | IDX_W (9) | Incoming-payload write index |
| rx_wr_data | input | 8 | Incoming-payload write data |
| miso | output | 1 | Serial data to the host |
| cfg_o | output | CFG_REGS*8 (80) | Configuration bytes, register n at bits [8n+7:8n] |
| tx_payload_o | output | PAYLOAD_BYTES*8 (256) | Outgoing payload, byte n at bits [8n+7:8n] |
| tx_addr_o | output | TXADDR_BYTES*8 (32) | Destination address, byte n at bits [8n+7:8n] |
| rx_payload_o | output | PAYLOAD_BYTES*8 (256) | Incoming payload, byte n at bits [8n+7:8n] |

## Verification
Some properties are checked on every cycle. MISO must carry status bit 7 right after select falls. A configuration write must never target an index above 9. An unrecognised command must never raise a write strobe. Out-of-range buffer writes must leave the contents unchanged. The bit and byte counters must clear when select rises. A channel command must keep the upper nibble of register 1.

Other behaviour only the bench scenarios can show, because it depends on the host's byte sequence. This covers address auto-increment across all sixteen start nibbles, clipping at register 9, read-back of every buffer up to and past its end, and realignment after a transaction aborted in mid-byte.

// File: rtl/srs_pkg.sv
package srs_pkg;

   typedef enum logic [3:0] {
      CK_NONE,
      CK_CFG_WR,
      CK_CFG_RD,
      CK_TXPL_WR,
      CK_TXPL_RD,
      CK_TXAD_WR,
      CK_TXAD_RD,
      CK_RXPL_RD,
      CK_CHAN
   } cmd_kind_e;

   localparam int STAT_MATCH_BIT = 7;
   localparam int STAT_READY_BIT = 5;

   function automatic cmd_kind_e classify_cmd(input logic [7:0] c);
      cmd_kind_e k;
      k = CK_NONE;
      if (c[7:4] == 4'h0)      k = CK_CFG_WR;
      else if (c[7:4] == 4'h1) k = CK_CFG_RD;
      else if (c[7:4] == 4'h8) k = CK_CHAN;
      else if (c == 8'h20)     k = CK_TXPL_WR;
      else if (c == 8'h21)     k = CK_TXPL_RD;
      else if (c == 8'h22)     k = CK_TXAD_WR;
      else if (c == 8'h23)     k = CK_TXAD_RD;
      else if (c == 8'h24)     k = CK_RXPL_RD;
      return k;
   endfunction

endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
   parameter int         STAGES  = 2,
   parameter int         WIDTH   = 3,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] pipe [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("srs_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
      end else begin
         pipe[0] <= d;
         for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/srs_shifter.sv
module srs_shifter (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sck_s,
   input  logic       cs_n_s,
   input  logic       mosi_s,
   input  logic [7:0] status_i,
   input  logic [7:0] next_tx_i,
   output logic       miso_o,
   output logic       txn_start_o,
   output logic       byte_done_o,
   output logic [7:0] rx_byte_o
);
   logic       sck_d, cs_d;
   logic [2:0] bit_cnt;
   logic [6:0] rx_sr;
   logic [7:0] tx_sr;
   logic       sck_rise, sck_fall;

   assign txn_start_o = cs_d && !cs_n_s;
   assign sck_rise    = !cs_n_s && sck_s && !sck_d;
   assign sck_fall    = !cs_n_s && !sck_s && sck_d;
   assign miso_o      = tx_sr[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d       <= 1'b0;
         cs_d        <= 1'b1;
         bit_cnt     <= '0;
         rx_sr       <= '0;
         tx_sr       <= '0;
         byte_done_o <= 1'b0;
         rx_byte_o   <= '0;
      end else begin
         sck_d       <= sck_s;
         cs_d        <= cs_n_s;
         byte_done_o <= 1'b0;
         if (cs_n_s) begin
            bit_cnt <= '0;
            tx_sr   <= '0;
         end else begin
            if (txn_start_o) begin
               tx_sr <= status_i;
            end else if (sck_fall) begin
               tx_sr <= (bit_cnt == 3'd0) ? next_tx_i : {tx_sr[6:0], 1'b0};
            end
            if (sck_rise) begin
               bit_cnt <= bit_cnt + 3'd1;
               rx_sr   <= {rx_sr[5:0], mosi_s};
               if (bit_cnt == 3'd7) begin
                  byte_done_o <= 1'b1;
                  rx_byte_o   <= {rx_sr, mosi_s};
               end
            end
         end
      end
   end

   // R2: status MSB appears on MISO right after select falls
   p_status_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
      txn_start_o |=> (miso_o == $past(status_i[7])));

   // R11: deselect clears the bit position
   p_bitcnt_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> (bit_cnt == 3'd0));

   // R1: a completed byte is reported for exactly one cycle
   p_byte_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done_o |=> !byte_done_o);
endmodule

// File: rtl/srs_byte_store.sv
module srs_byte_store #(
   parameter int DEPTH = 32,
   parameter int IDX_W = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [IDX_W-1:0]   widx,
   input  logic [7:0]         wdata,
   input  logic [IDX_W-1:0]   ridx,
   output logic [7:0]         rdata,
   output logic [DEPTH*8-1:0] flat_o
);
   logic [7:0] mem [DEPTH];

   if (DEPTH < 1 || DEPTH >= (1 << IDX_W)) begin : g_bad_depth
      $error("srs_byte_store: DEPTH must be 1 .. 2**IDX_W-1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         for (int i = 0; i < DEPTH; i++)
            if (widx == IDX_W'(i)) mem[i] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < DEPTH; i++)
         if (ridx == IDX_W'(i)) rdata = mem[i];
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_flat
      assign flat_o[g*8 +: 8] = mem[g];
   end

   // R10: writes beyond the last entry leave contents untouched
   p_oob_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (widx >= IDX_W'(DEPTH))) |=> $stable(flat_o));
endmodule

// File: rtl/srs_ctrl.sv
module srs_ctrl
   import srs_pkg::*;
#(
   parameter int CFG_REGS = 10,
   parameter int IDX_W    = 9,
   parameter int CNT_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n_s,
   input  logic             txn_start,
   input  logic             byte_done,
   input  logic [7:0]       rx_byte,
   input  logic             addr_match,
   input  logic             data_ready,
   input  logic [3:0]       reg1_hi,
   input  logic [7:0]       cfg_rd,
   input  logic [7:0]       txpl_rd,
   input  logic [7:0]       txad_rd,
   input  logic [7:0]       rxpl_rd,
   output logic [7:0]       status,
   output logic [7:0]       next_tx,
   output logic             cfg_we,
   output logic [IDX_W-1:0] cfg_widx,
   output logic [7:0]       cfg_wdata,
   output logic [IDX_W-1:0] cfg_ridx,
   output logic             txpl_we,
   output logic             txad_we,
   output logic [IDX_W-1:0] buf_idx
);
   localparam logic [IDX_W-1:0] CFG_LIM = IDX_W'(CFG_REGS);

   logic [CNT_W-1:0] byte_cnt;
   logic [7:0]       cmd_q;
   cmd_kind_e        kind_q, kind_now;
   logic             first;
   logic [IDX_W-1:0] start, cfg_addr;
   logic             start_ok;

   if (CNT_W > IDX_W - 1) begin : g_bad_cnt
      $error("srs_ctrl: CNT_W must leave headroom in IDX_W");
   end

   assign kind_now = classify_cmd(rx_byte);
   assign first    = (byte_cnt == '0);
   assign buf_idx  = IDX_W'(byte_cnt - CNT_W'(1));
   assign start    = IDX_W'(cmd_q[3:0]);
   assign start_ok = start < CFG_LIM;
   assign cfg_addr = start + buf_idx;
   assign cfg_ridx = start_ok ? cfg_addr : '1;

   always_comb begin
      status = '0;
      status[STAT_MATCH_BIT] = addr_match;
      status[STAT_READY_BIT] = data_ready;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_cnt <= '0;
         cmd_q    <= '0;
         kind_q   <= CK_NONE;
      end else if (cs_n_s || txn_start) begin
         byte_cnt <= '0;
      end else if (byte_done) begin
         if (byte_cnt != '1) byte_cnt <= byte_cnt + CNT_W'(1);
         if (first) begin
            cmd_q  <= rx_byte;
            kind_q <= kind_now;
         end
      end
   end

   always_comb begin
      cfg_we    = 1'b0;
      cfg_widx  = '0;
      cfg_wdata = rx_byte;
      if (byte_done) begin
         if (first) begin
            if (kind_now == CK_CHAN) begin
               cfg_we    = 1'b1;
               cfg_widx  = IDX_W'(1);
               cfg_wdata = {reg1_hi, rx_byte[3:0]};
            end
         end else if (kind_q == CK_CFG_WR) begin
            if (start_ok && (cfg_addr < CFG_LIM)) begin
               cfg_we   = 1'b1;
               cfg_widx = cfg_addr;
            end
         end else if (kind_q == CK_CHAN) begin
            if (byte_cnt == CNT_W'(1)) begin
               cfg_we   = 1'b1;
               cfg_widx = '0;
            end
         end
      end
   end

   assign txpl_we = byte_done && !first && (kind_q == CK_TXPL_WR);
   assign txad_we = byte_done && !first && (kind_q == CK_TXAD_WR);

   always_comb begin
      case (kind_q)
         CK_CFG_RD:  next_tx = cfg_rd;
         CK_TXPL_RD: next_tx = txpl_rd;
         CK_TXAD_RD: next_tx = txad_rd;
         CK_RXPL_RD: next_tx = rxpl_rd;
         default:    next_tx = 8'h00;
      endcase
   end

   // R5: no configuration write ever targets an index past the last register
   p_cfg_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |-> (cfg_widx < CFG_LIM));

   // R12: an unrecognised command raises no write strobe
   p_unknown_silent_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && !first && kind_q == CK_NONE) |-> !(cfg_we || txpl_we || txad_we));

   // R11: a new select window restarts byte counting
   p_cnt_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
      txn_start |=> (byte_cnt == '0));

   // R9: channel command keeps the upper nibble of register 1
   p_reg1_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && first) |-> (cfg_wdata[7:4] == reg1_hi));
endmodule

// File: rtl/spi_radio_ctl_port.sv
module spi_radio_ctl_port #(
   parameter int CFG_REGS      = 10,
   parameter int PAYLOAD_BYTES = 32,
   parameter int TXADDR_BYTES  = 4,
   parameter int IDX_W         = 9,
   parameter int SYNC_STAGES   = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sck,
   input  logic                       cs_n,
   input  logic                       mosi,
   input  logic                       addr_match,
   input  logic                       data_ready,
   input  logic                       rx_wr_en,
   input  logic [IDX_W-1:0]           rx_wr_idx,
   input  logic [7:0]                 rx_wr_data,
   output logic                       miso,
   output logic [CFG_REGS*8-1:0]      cfg_o,
   output logic [PAYLOAD_BYTES*8-1:0] tx_payload_o,
   output logic [TXADDR_BYTES*8-1:0]  tx_addr_o,
   output logic [PAYLOAD_BYTES*8-1:0] rx_payload_o
);
   localparam int CNT_W = IDX_W - 1;

   if (CFG_REGS < 2 || CFG_REGS > 16) begin : g_bad_cfg
      $error("spi_radio_ctl_port: CFG_REGS must be 2 .. 16");
   end
   if (PAYLOAD_BYTES < 1 || PAYLOAD_BYTES > (1 << CNT_W) - 2) begin : g_bad_pl
      $error("spi_radio_ctl_port: PAYLOAD_BYTES out of range");
   end

   logic [2:0] pins_s;
   logic       sck_s, cs_n_s, mosi_s;
   logic       txn_start, byte_done;
   logic [7:0] rx_byte, status, next_tx;
   logic       cfg_we, txpl_we, txad_we;
   logic [IDX_W-1:0] cfg_widx, cfg_ridx, buf_idx;
   logic [7:0] cfg_wdata, cfg_rd, txpl_rd, txad_rd, rxpl_rd;

   srs_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b010)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({sck, cs_n, mosi}), .q(pins_s));
   assign {sck_s, cs_n_s, mosi_s} = pins_s;

   srs_shifter u_shift (
      .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
      .status_i(status), .next_tx_i(next_tx), .miso_o(miso),
      .txn_start_o(txn_start), .byte_done_o(byte_done), .rx_byte_o(rx_byte));

   srs_ctrl #(.CFG_REGS(CFG_REGS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .txn_start(txn_start),
      .byte_done(byte_done), .rx_byte(rx_byte), .addr_match(addr_match),
      .data_ready(data_ready), .reg1_hi(cfg_o[15:12]), .cfg_rd(cfg_rd),
      .txpl_rd(txpl_rd), .txad_rd(txad_rd), .rxpl_rd(rxpl_rd),
      .status(status), .next_tx(next_tx), .cfg_we(cfg_we), .cfg_widx(cfg_widx),
      .cfg_wdata(cfg_wdata), .cfg_ridx(cfg_ridx), .txpl_we(txpl_we),
      .txad_we(txad_we), .buf_idx(buf_idx));

   srs_byte_store #(.DEPTH(CFG_REGS), .IDX_W(IDX_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .widx(cfg_widx), .wdata(cfg_wdata),
      .ridx(cfg_ridx), .rdata(cfg_rd), .flat_o(cfg_o));

   srs_byte_store #(.DEPTH(PAYLOAD_BYTES), .IDX_W(IDX_W)) u_txpl (
      .clk(clk), .rst_n(rst_n), .we(txpl_we), .widx(buf_idx), .wdata(rx_byte),
      .ridx(buf_idx), .rdata(txpl_rd), .flat_o(tx_payload_o));

   srs_byte_store #(.DEPTH(TXADDR_BYTES), .IDX_W(IDX_W)) u_txad (
      .clk(clk), .rst_n(rst_n), .we(txad_we), .widx(buf_idx), .wdata(rx_byte),
      .ridx(buf_idx), .rdata(txad_rd), .flat_o(tx_addr_o));

   srs_byte_store #(.DEPTH(PAYLOAD_BYTES), .IDX_W(IDX_W)) u_rxpl (
      .clk(clk), .rst_n(rst_n), .we(rx_wr_en), .widx(rx_wr_idx), .wdata(rx_wr_data),
      .ridx(buf_idx), .rdata(rxpl_rd), .flat_o(rx_payload_o));
endmodule

// File: tb/spi_radio_ctl_port_tb.sv
`timescale 1ns/1ps
module spi_radio_ctl_port_tb_top;
   localparam int HALF = 32;

   logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, mosi = 0;
   logic addr_match = 0, data_ready = 0, rx_wr_en = 0;
   logic [8:0] rx_wr_idx = '0;
   logic [7:0] rx_wr_data = '0;
   logic miso;
   logic [79:0]  cfg_o;
   logic [255:0] tx_payload_o, rx_payload_o;
   logic [31:0]  tx_addr_o;

   spi_radio_ctl_port dut_i (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
      .addr_match(addr_match), .data_ready(data_ready), .rx_wr_en(rx_wr_en),
      .rx_wr_idx(rx_wr_idx), .rx_wr_data(rx_wr_data), .miso(miso),
      .cfg_o(cfg_o), .tx_payload_o(tx_payload_o), .tx_addr_o(tx_addr_o),
      .rx_payload_o(rx_payload_o));

   always #2 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   logic [7:0] mo [64];
   logic [7:0] mi [64];
   logic [7:0] cfg_m [10];
   logic [7:0] txp_m [32];
   logic [7:0] txa_m [4];
   logic [7:0] rxp_m [32];

   task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic spi_byte(input logic [7:0] b, input int nbits, output logic [7:0] r);
      r = '0;
      for (int i = 7; i > 7 - nbits; i--) begin
         mosi = b[i];
         #HALF;
         r[i] = miso;
         sck = 1;
         #HALF;
         sck = 0;
      end
   endtask

   // n full bytes from mo[], then an optional partial byte of pbits bits
   task automatic xfer(input int n, input int pbits);
      logic [7:0] r;
      cs_n = 0;
      #HALF;
      for (int k = 0; k < n; k++) begin
         spi_byte(mo[k], 8, r);
         mi[k] = r;
      end
      if (pbits > 0) spi_byte(mo[n], pbits, r);
      #HALF;
      cs_n = 1;
      #(4*HALF);
   endtask

   function automatic logic [255:0] cfg_flat();
      logic [255:0] v = '0;
      for (int i = 0; i < 10; i++) v[i*8 +: 8] = cfg_m[i];
      return v;
   endfunction

   initial begin
      #760000;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 10; i++) cfg_m[i] = 0;
      for (int i = 0; i < 32; i++) begin txp_m[i] = 0; rxp_m[i] = 0; end
      for (int i = 0; i < 4; i++) txa_m[i] = 0;
      #21 rst_n = 1;
      #41;

      // R13: reset state on ports and through a read
      chk("R13 cfg", 256'(cfg_o), 0);
      chk("R13 txpl", 256'(tx_payload_o), 0);
      chk("R13 txad", 256'(tx_addr_o), 0);
      mo[0] = 8'h10;
      for (int k = 1; k < 11; k++) mo[k] = 8'hAA;
      xfer(11, 0);
      for (int k = 1; k < 11; k++) chk("R13 cfg read", 256'(mi[k]), 0);

      // R2/R12: status byte sweep with an unrecognised command
      for (int s = 0; s < 4; s++) begin
         addr_match = s[1]; data_ready = s[0];
         mo[0] = 8'hFF; mo[1] = 8'h12; mo[2] = 8'h34;
         xfer(3, 0);
         chk("R2 status", 256'(mi[0]), 256'({s[1], 1'b0, s[0], 5'b0}));
         chk("R12 unknown miso", 256'({mi[1], mi[2]}), 0);
         chk("R12 unknown state", 256'(cfg_o), cfg_flat());
      end
      addr_match = 0; data_ready = 0;

      // R3/R5: write sweep over every start nibble
      for (int st = 0; st < 16; st++) begin
         mo[0] = 8'(st);
         for (int k = 0; k < 11; k++) begin
            mo[k+1] = 8'(st*16 + k + 1);
            if (st <= 9 && st + k <= 9) cfg_m[st+k] = mo[k+1];
         end
         xfer(12, 0);
         chk("R3 R5 cfg write", 256'(cfg_o), cfg_flat());
         chk("R12 write miso", 256'({mi[1], mi[5]}), 0);
      end

      // R4/R5/R1: read sweep over every start nibble
      for (int st = 0; st < 16; st++) begin
         mo[0] = 8'(8'h10 | st);
         for (int k = 1; k < 12; k++) mo[k] = 8'h5A;
         xfer(12, 0);
         for (int k = 0; k < 11; k++)
            chk("R4 R5 R1 cfg read", 256'(mi[k+1]),
                (st <= 9 && st + k <= 9) ? 256'(cfg_m[st+k]) : 0);
      end

      // R6/R10: outgoing payload write and read past its end
      mo[0] = 8'h20;
      for (int k = 0; k < 34; k++) begin
         mo[k+1] = 8'(k*7 + 3);
         if (k < 32) txp_m[k] = mo[k+1];
      end
      xfer(35, 0);
      begin
         logic [255:0] v = '0;
         for (int i = 0; i < 32; i++) v[i*8 +: 8] = txp_m[i];
         chk("R6 txpl port", tx_payload_o, v);
      end
      mo[0] = 8'h21;
      xfer(35, 0);
      for (int k = 0; k < 34; k++)
         chk("R6 R10 txpl read", 256'(mi[k+1]), k < 32 ? 256'(txp_m[k]) : 0);

      // R7/R10: destination address
      mo[0] = 8'h22;
      for (int k = 0; k < 6; k++) begin
         mo[k+1] = 8'(8'hC0 + k*5);
         if (k < 4) txa_m[k] = mo[k+1];
      end
      xfer(7, 0);
      chk("R7 txad port", 256'(tx_addr_o), 256'({txa_m[3], txa_m[2], txa_m[1], txa_m[0]}));
      mo[0] = 8'h23;
      xfer(7, 0);
      for (int k = 0; k < 6; k++)
         chk("R7 R10 txad read", 256'(mi[k+1]), k < 4 ? 256'(txa_m[k]) : 0);

      // R8/R10: incoming payload filled from the radio side
      for (int i = 0; i < 33; i++) begin
         @(negedge clk);
         rx_wr_en = 1;
         rx_wr_idx = (i == 32) ? 9'd40 : 9'(i);
         rx_wr_data = 8'(i) ^ 8'hA5;
         if (i < 32) rxp_m[i] = rx_wr_data;
      end
      @(negedge clk);
      rx_wr_en = 0;
      #5;
      mo[0] = 8'h24;
      xfer(35, 0);
      for (int k = 0; k < 34; k++)
         chk("R8 R10 rxpl read", 256'(mi[k+1]), k < 32 ? 256'(rxp_m[k]) : 0);

      // R9: channel command sweep, register 1 upper nibble preset
      mo[0] = 8'h01; mo[1] = 8'hF0; cfg_m[1] = 8'hF0;
      xfer(2, 0);
      for (int c = 0; c < 16; c++) begin
         mo[0] = 8'(8'h80 | c); mo[1] = 8'(c*17 + 1); mo[2] = 8'h99;
         cfg_m[1] = {cfg_m[1][7:4], 4'(c)};
         cfg_m[0] = mo[1];
         xfer(3, 0);
         chk("R9 chan", 256'(cfg_o), cfg_flat());
      end

      // R11: abort mid-byte, then realignment
      mo[0] = 8'h00; mo[1] = 8'h5A; mo[2] = 8'h33;
      cfg_m[0] = 8'h5A;
      xfer(2, 4);
      chk("R11 partial dropped", 256'(cfg_o), cfg_flat());
      mo[0] = 8'h02;
      xfer(0, 3);
      chk("R11 partial cmd", 256'(cfg_o), cfg_flat());
      addr_match = 1;
      mo[0] = 8'h05; mo[1] = 8'h77; cfg_m[5] = 8'h77;
      xfer(2, 0);
      chk("R11 realign status", 256'(mi[0]), 256'(8'h80));
      chk("R11 realign write", 256'(cfg_o), cfg_flat());
      addr_match = 0;

      // R12: unrecognised command with data leaves every buffer unchanged
      mo[0] = 8'h30;
      for (int k = 1; k < 6; k++) mo[k] = 8'h11;
      xfer(6, 0);
      chk("R12 cfg kept", 256'(cfg_o), cfg_flat());
      chk("R12 txad kept", 256'(tx_addr_o), 256'({txa_m[3], txa_m[2], txa_m[1], txa_m[0]}));

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule